// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block sequences the sending of a multi-byte in-frame response on a byte-oriented serial data link. The host arms a response by loading the first byte into a single data register and choosing one of two response modes: with a trailing check byte or without it. The arming must happen before the end-of-data symbol of the main message frame. When that symbol is seen, the sequencer asks the symbol layer for a normalization bit and then for the first byte. It then hands out one byte per host write, and it paces the host with a data-register-empty flag.

The host marks the final byte by raising an end-of-data request after writing it. The sequencer then sends the inverted check byte if that mode was chosen, and then an end-of-data symbol. It waits for end of frame before it reports completion. Loss of arbitration drops the attempt but keeps the mode armed, so the response is retried after the next message. A receive error or a response from another node disarms it. One prioritized status code tells the host what needs attention.

The symbol layer asserts `tx_take` for one cycle when it accepts the pending request. Byte sequencing follows that handshake only, never receive-side events.

Top module: `ifr_tx_seq`

## Requirements
- R1: After reset there is no pending request, the empty flag, both mode bits and the end-of-data request are 0, and the status code is 0.
- R2: An end-of-data symbol starts a response only if a mode bit is already set. With neither bit set, `tx_req` stays 0.
- R3: A started response first requests a normalization bit (`tx_kind` 0) and then a data byte (`tx_kind` 1) carrying the register contents. A second write before end-of-data replaces the first byte.
- R4: When a non-final data byte is taken, the empty flag rises and the status code shows 2. A host write clears the flag and presents the new byte as the next data request.
- R5: A byte taken with the end-of-data request set is final, and so is the last taken byte when the request is set while the flag is empty. In check mode it is followed by a check request (`tx_kind` 2) and then an end-of-data request (`tx_kind` 3). Otherwise the end-of-data request follows directly.
- R6: The check byte is the bitwise inverse of an 8-bit CRC over all response bytes in the order sent, most significant bit first. The polynomial is x^8+x^4+x^3+x^2+1 (0x1D) and the preset is 0xFF.
- R7: After the end-of-data request is taken, an end-of-frame input returns the block to idle. It clears both mode bits and the end-of-data request, and it posts status code 1.
- R8: Arbitration loss during a response drops the request and clears the end-of-data request and the empty flag. The mode bit is kept, status code 3 is posted, and the response restarts at the next end-of-data symbol.
- R9: A receive error clears both mode bits and the end-of-data request and posts status code 4. A response seen from another node also clears both mode bits.
- R10: The status code is the highest pending item in the order 4 (receive error), 3 (arbitration lost), 2 (empty), 1 (complete), and 0 when nothing is pending. A status acknowledge clears the shown item, except the empty flag, which only a write clears.
- R11: Selecting one mode clears the other mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write pulse to the data register |
| host_wdata | input | DW | Data register write value |
| host_set_crc | input | 1 | Arm response with check byte |
| host_set_nocrc | input | 1 | Arm response without check byte |
| host_set_last | input | 1 | Set end-of-data request |
| host_st_ack | input | 1 | Acknowledge the shown status item |
| bus_eod | input | 1 | End-of-data symbol detected |
| bus_eof | input | 1 | End-of-frame detected |
| bus_arb_lost | input | 1 | Arbitration lost |
| bus_rx_err | input | 1 | Receive error |
| bus_foreign_ifr | input | 1 | Another node sent a response |
| tx_take | input | 1 | Symbol layer accepts the pending request |
| tx_req | output | 1 | Request pending |
| tx_kind | output | 2 | 0 normalization, 1 data, 2 check, 3 end-of-data |
| tx_byte | output | DW | Byte for data or check requests |
| tx_empty | output | 1 | Data register empty flag |
| mode_crc | output | 1 | Armed with check byte |
| mode_nocrc | output | 1 | Armed without check byte |
| last_req | output | 1 | End-of-data request bit |
| status_code | output | 3 | Highest pending status |

## Verification
Response lengths of one to four bytes are run in both modes. Each length is run twice: once with the end-of-data request raised before the final byte is taken, and once after it has been taken. This separates the two ways a final byte can be recognized and shows whether the check byte is inserted or skipped. A sweep over all 256 single-byte responses compares the check byte with an arithmetic CRC, which exposes polynomial, preset, bit order and inversion faults. Short abort sequences cover arbitration loss with a retry, receive error, a response from another node, overwriting the first byte, and status priority under acknowledge.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [1:0] {
    TK_NORM = 2'd0,
    TK_DATA = 2'd1,
    TK_CRC  = 2'd2,
    TK_EOD  = 2'd3
  } tx_kind_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_NORM, SQ_DATA, SQ_WAIT, SQ_CRC, SQ_EOD, SQ_EOF
  } seq_state_t;

  localparam logic [2:0] ST_NONE  = 3'd0;
  localparam logic [2:0] ST_DONE  = 3'd1;
  localparam logic [2:0] ST_EMPTY = 3'd2;
  localparam logic [2:0] ST_ARB   = 3'd3;
  localparam logic [2:0] ST_ERR   = 3'd4;
endpackage

// File: rtl/ifr_crc.sv
module ifr_crc #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [CW-1:0] POLY = 8'h1D,
  parameter logic [CW-1:0] INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc
);
  function automatic logic [CW-1:0] crc_next(input logic [CW-1:0] c, input logic [DW-1:0] d);
    logic [CW-1:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      if (r[CW-1] ^ d[i]) r = (r << 1) ^ POLY;
      else r = r << 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || init) crc <= INIT;
    else if (upd) crc <= crc_next(crc, din);
  end
endmodule

// File: rtl/ifr_status.sv
module ifr_status
  import ifr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_err,
  input  logic       set_arb,
  input  logic       set_done,
  input  logic       ack,
  input  logic       empty,
  output logic [2:0] code
);
  logic p_err, p_arb, p_done;

  always_comb begin
    if (p_err) code = ST_ERR;
    else if (p_arb) code = ST_ARB;
    else if (empty) code = ST_EMPTY;
    else if (p_done) code = ST_DONE;
    else code = ST_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_err <= 1'b0;
      p_arb <= 1'b0;
      p_done <= 1'b0;
    end else begin
      if (ack) begin
        if (p_err) p_err <= 1'b0;
        else if (p_arb) p_arb <= 1'b0;
        else if (!empty && p_done) p_done <= 1'b0;
      end
      if (set_err) p_err <= 1'b1;
      if (set_arb) p_arb <= 1'b1;
      if (set_done) p_done <= 1'b1;
    end
  end

  AST_ACK_DROPS_ERR: assert property (@(posedge clk) disable iff (rst)
    (ack && p_err && !set_err) |=> (code != ST_ERR)); // R10
endmodule

// File: rtl/ifr_ctrl.sv
module ifr_ctrl
  import ifr_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_set_crc,
  input  logic          host_set_nocrc,
  input  logic          host_set_last,
  input  logic          bus_eod,
  input  logic          bus_eof,
  input  logic          bus_arb_lost,
  input  logic          bus_rx_err,
  input  logic          bus_foreign_ifr,
  input  logic          tx_take,
  input  logic [CW-1:0] crc_val,
  output logic          crc_init,
  output logic          crc_upd,
  output logic [DW-1:0] dreg,
  output logic          tx_req,
  output logic [1:0]    tx_kind,
  output logic [DW-1:0] tx_byte,
  output logic          tx_empty,
  output logic          mode_crc,
  output logic          mode_nocrc,
  output logic          last_req,
  output logic          ev_err,
  output logic          ev_arb,
  output logic          ev_done
);
  seq_state_t state;
  logic use_crc, busy, mode_any;

  assign busy     = (state != SQ_IDLE);
  assign mode_any = mode_crc | mode_nocrc;

  always_comb begin
    ev_err  = bus_rx_err;
    ev_arb  = bus_arb_lost && busy && !bus_rx_err;
    ev_done = (state == SQ_EOF) && bus_eof && !bus_rx_err && !bus_arb_lost && !bus_foreign_ifr;
    crc_init = (state == SQ_IDLE) && bus_eod && mode_any && !bus_rx_err && !bus_foreign_ifr;
    crc_upd  = (state == SQ_DATA) && tx_take && !bus_rx_err && !bus_arb_lost && !bus_foreign_ifr;
    tx_req  = 1'b0;
    tx_kind = TK_NORM;
    tx_byte = '0;
    case (state)
      SQ_NORM: begin tx_req = 1'b1; tx_kind = TK_NORM; end
      SQ_DATA: begin tx_req = 1'b1; tx_kind = TK_DATA; tx_byte = dreg; end
      SQ_CRC:  begin tx_req = 1'b1; tx_kind = TK_CRC;  tx_byte = DW'(~crc_val); end
      SQ_EOD:  begin tx_req = 1'b1; tx_kind = TK_EOD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      dreg <= '0;
      tx_empty <= 1'b0;
      mode_crc <= 1'b0;
      mode_nocrc <= 1'b0;
      last_req <= 1'b0;
      use_crc <= 1'b0;
    end else begin
      if (host_set_last) last_req <= 1'b1;
      if (host_set_crc) begin
        mode_crc <= 1'b1;
        mode_nocrc <= 1'b0;
      end else if (host_set_nocrc) begin
        mode_nocrc <= 1'b1;
        mode_crc <= 1'b0;
      end
      if (bus_rx_err) begin
        state <= SQ_IDLE;
        mode_crc <= 1'b0;
        mode_nocrc <= 1'b0;
        last_req <= 1'b0;
        tx_empty <= 1'b0;
      end else if (bus_arb_lost && busy) begin
        state <= SQ_IDLE;
        last_req <= 1'b0;
        tx_empty <= 1'b0;
      end else if (bus_foreign_ifr) begin
        mode_crc <= 1'b0;
        mode_nocrc <= 1'b0;
        if (busy) begin
          state <= SQ_IDLE;
          last_req <= 1'b0;
          tx_empty <= 1'b0;
        end
      end else begin
        case (state)
          SQ_IDLE: if (bus_eod && mode_any) begin
            state <= SQ_NORM;
            use_crc <= mode_crc;
          end
          SQ_NORM: if (tx_take) state <= SQ_DATA;
          SQ_DATA: if (tx_take) begin
            if (last_req) state <= use_crc ? SQ_CRC : SQ_EOD;
            else begin
              state <= SQ_WAIT;
              tx_empty <= 1'b1;
            end
          end
          SQ_WAIT: begin
            if (!tx_empty) state <= SQ_DATA;
            else if (last_req) begin
              state <= use_crc ? SQ_CRC : SQ_EOD;
              tx_empty <= 1'b0;
            end
          end
          SQ_CRC: if (tx_take) state <= SQ_EOD;
          SQ_EOD: if (tx_take) state <= SQ_EOF;
          SQ_EOF: if (bus_eof) begin
            state <= SQ_IDLE;
            mode_crc <= 1'b0;
            mode_nocrc <= 1'b0;
            last_req <= 1'b0;
          end
          default: state <= SQ_IDLE;
        endcase
      end
      if (host_wr) begin
        dreg <= host_wdata;
        tx_empty <= 1'b0;
      end
    end
  end

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_crc, mode_nocrc})); // R11
  AST_NO_MODE_NO_START: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && bus_eod && !mode_any) |=> !tx_req); // R2
  AST_ARB_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_arb_lost && !bus_rx_err && !bus_foreign_ifr && !host_set_crc && !host_set_nocrc)
    |=> (mode_crc == $past(mode_crc)) && (mode_nocrc == $past(mode_nocrc)) && !last_req && !tx_req); // R8
  AST_ERR_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
    bus_rx_err |=> !mode_crc && !mode_nocrc && !tx_req); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_take && !bus_rx_err && !bus_arb_lost && !bus_foreign_ifr)
    |=> tx_req && $stable(tx_kind)); // R5
endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq
  import ifr_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic [CW-1:0] CRC_POLY = 8'h1D,
  parameter logic [CW-1:0] CRC_INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_set_crc,
  input  logic          host_set_nocrc,
  input  logic          host_set_last,
  input  logic          host_st_ack,
  input  logic          bus_eod,
  input  logic          bus_eof,
  input  logic          bus_arb_lost,
  input  logic          bus_rx_err,
  input  logic          bus_foreign_ifr,
  input  logic          tx_take,
  output logic          tx_req,
  output logic [1:0]    tx_kind,
  output logic [DW-1:0] tx_byte,
  output logic          tx_empty,
  output logic          mode_crc,
  output logic          mode_nocrc,
  output logic          last_req,
  output logic [2:0]    status_code
);
  logic [CW-1:0] crc_val;
  logic [DW-1:0] dreg;
  logic crc_init, crc_upd, ev_err, ev_arb, ev_done;

  ifr_ctrl #(.DW(DW), .CW(CW)) u_ctrl (
    .clk, .rst, .host_wr, .host_wdata, .host_set_crc, .host_set_nocrc,
    .host_set_last, .bus_eod, .bus_eof, .bus_arb_lost, .bus_rx_err,
    .bus_foreign_ifr, .tx_take, .crc_val, .crc_init, .crc_upd, .dreg,
    .tx_req, .tx_kind, .tx_byte, .tx_empty, .mode_crc, .mode_nocrc,
    .last_req, .ev_err, .ev_arb, .ev_done
  );

  ifr_crc #(.DW(DW), .CW(CW), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk, .rst, .init(crc_init), .upd(crc_upd), .din(dreg), .crc(crc_val)
  );

  ifr_status u_status (
    .clk, .rst, .set_err(ev_err), .set_arb(ev_arb), .set_done(ev_done),
    .ack(host_st_ack), .empty(tx_empty), .code(status_code)
  );
endmodule

// File: tb/ifr_tx_seq_bench.sv
module ifr_tx_seq_bench;
  localparam int DW = 8;
  localparam int CLK_NS = 20;

  logic clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic rst = 1'b1;
  logic host_wr = 0, host_set_crc = 0, host_set_nocrc = 0, host_set_last = 0, host_st_ack = 0;
  logic [DW-1:0] host_wdata = '0;
  logic bus_eod = 0, bus_eof = 0, bus_arb_lost = 0, bus_rx_err = 0, bus_foreign_ifr = 0, tx_take = 0;
  logic tx_req, tx_empty, mode_crc, mode_nocrc, last_req;
  logic [1:0] tx_kind;
  logic [DW-1:0] tx_byte;
  logic [2:0] status_code;

  ifr_tx_seq u_ifr_tx_seq (
    .clk, .rst, .host_wr, .host_wdata, .host_set_crc, .host_set_nocrc,
    .host_set_last, .host_st_ack, .bus_eod, .bus_eof, .bus_arb_lost,
    .bus_rx_err, .bus_foreign_ifr, .tx_take, .tx_req, .tx_kind, .tx_byte,
    .tx_empty, .mode_crc, .mode_nocrc, .last_req, .status_code
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic wr(input logic [DW-1:0] b);
    host_wr = 1; host_wdata = b; step(); host_wr = 0;
  endtask
  task automatic p_crc();   host_set_crc = 1;    step(); host_set_crc = 0;    endtask
  task automatic p_nocrc(); host_set_nocrc = 1;  step(); host_set_nocrc = 0;  endtask
  task automatic p_last();  host_set_last = 1;   step(); host_set_last = 0;   endtask
  task automatic p_ack();   host_st_ack = 1;     step(); host_st_ack = 0;     endtask
  task automatic p_eod();   bus_eod = 1;         step(); bus_eod = 0;         endtask
  task automatic p_eof();   bus_eof = 1;         step(); bus_eof = 0;         endtask
  task automatic p_arb();   bus_arb_lost = 1;    step(); bus_arb_lost = 0;    endtask
  task automatic p_err();   bus_rx_err = 1;      step(); bus_rx_err = 0;      endtask
  task automatic p_frgn();  bus_foreign_ifr = 1; step(); bus_foreign_ifr = 0; endtask
  task automatic p_take();  tx_take = 1;         step(); tx_take = 0;         endtask

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[7] ^ d[k]) r = (r << 1) ^ 8'h1D;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] byte_of(input int s, input int i);
    return 8'((s * 37) + (i * 91) + 5);
  endfunction

  task automatic run_ifr(input int n, input bit crc, input bit late, input int seed, input bit only_crc);
    logic [7:0] c;
    logic [7:0] b;
    c = 8'hFF;
    b = byte_of(seed, 0);
    wr(b);
    if (crc) p_crc(); else p_nocrc();
    p_eod();
    if (!only_crc) begin
      chk("R2 start", tx_req, 1);
      chk("R3 norm bit", tx_kind, 0);
    end
    p_take();
    for (int i = 0; i < n; i++) begin
      if (!only_crc) begin
        chk("R3 data kind", tx_kind, 1);
        chk("R4 data byte", tx_byte, b);
      end
      c = crc_step(c, b);
      if (i == n - 1 && !late) p_last();
      p_take();
      if (i < n - 1) begin
        if (!only_crc) begin
          chk("R4 empty set", tx_empty, 1);
          chk("R4 status empty", status_code, 2);
        end
        b = byte_of(seed, i + 1);
        wr(b);
        if (!only_crc) chk("R4 empty clr", tx_empty, 0);
        step();
      end
    end
    if (late) begin
      if (!only_crc) chk("R4 empty final", tx_empty, 1);
      p_last();
      step();
    end
    if (crc) begin
      chk("R6 crc byte", tx_byte, 8'(~c));
      if (!only_crc) chk("R5 crc kind", tx_kind, 2);
      p_take();
    end
    if (!only_crc) begin
      chk("R5 eod kind", tx_kind, 3);
      chk("R5 empty low", tx_empty, 0);
    end
    p_take();
    if (!only_crc) chk("R7 no req", tx_req, 0);
    p_eof();
    if (!only_crc) begin
      chk("R7 mode clr", {mode_crc, mode_nocrc}, 0);
      chk("R7 last clr", last_req, 0);
      chk("R7 status done", status_code, 1);
    end
    p_ack();
    if (!only_crc) chk("R10 ack done", status_code, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 0;
    step();
    chk("R1 req", tx_req, 0);
    chk("R1 empty", tx_empty, 0);
    chk("R1 mode", {mode_crc, mode_nocrc}, 0);
    chk("R1 last", last_req, 0);
    chk("R1 status", status_code, 0);

    wr(8'h11);
    p_eod();
    chk("R2 no mode", tx_req, 0);

    p_crc();
    p_nocrc();
    chk("R11 crc clr", mode_crc, 0);
    chk("R11 nocrc set", mode_nocrc, 1);
    p_crc();
    chk("R11 nocrc clr", mode_nocrc, 0);

    wr(8'hA5);
    wr(8'h3C);
    p_eod();
    chk("R3 norm", tx_kind, 0);
    p_take();
    chk("R3 overwrite", tx_byte, 8'h3C);

    p_last();
    p_arb();
    chk("R8 req drop", tx_req, 0);
    chk("R8 last clr", last_req, 0);
    chk("R8 mode kept", mode_crc, 1);
    chk("R8 status arb", status_code, 3);
    p_ack();
    chk("R10 ack arb", status_code, 0);
    p_eod();
    chk("R8 retry", tx_req, 1);
    chk("R8 retry norm", tx_kind, 0);
    p_take();
    p_arb();
    p_err();
    chk("R9 mode clr", {mode_crc, mode_nocrc}, 0);
    chk("R10 err over arb", status_code, 4);
    p_ack();
    chk("R10 arb next", status_code, 3);
    p_ack();
    chk("R10 cleared", status_code, 0);
    p_eod();
    chk("R9 no start", tx_req, 0);

    p_nocrc();
    p_frgn();
    chk("R9 foreign clr", {mode_crc, mode_nocrc}, 0);
    p_eod();
    chk("R9 foreign no start", tx_req, 0);

    for (int n = 1; n <= 4; n++)
      for (int cm = 0; cm < 2; cm++)
        for (int lt = 0; lt < 2; lt++)
          run_ifr(n, cm[0], lt[0], n * 7 + cm * 3 + lt, 1'b0);

    for (int v = 0; v < 256; v++) run_ifr(1, 1'b1, 1'b0, v, 1'b1);

    finished = 1;
    summary();
    $finish;
  end
endmodule